// File: doc/BRIEF.md
# Ping-Pong Audio Capture Buffer

This block takes packed audio samples, each either two or four bytes wide, and lays them into a 128-byte circular store treated as two 64-byte halves. Bytes of each sample land at consecutive addresses, least significant byte first. A sample may straddle the boundary between halves.

When a half has received its last byte, the block asserts a transfer request and names that half. A drain engine reads the half one byte at a time through a byte address. It then pulses an acknowledge, which returns the half to the writer. Capture continues into the other half while a request is pending, so the writer never waits.

When the unread contents leave too little room for an arriving sample, that sample is discarded whole. A sticky bandwidth-error flag then rises and stays high until software clears it. As a sizing guide for stereo capture, a full half must be drained within 16 sample periods for 16-bit samples, or within 8 periods for 32-bit samples.

Top module: `pingpong_capbuf`

## Requirements
- R1: After reset `dma_req` and `bw_err` are low, and the writer starts at byte 0 of half 0.
- R2: A sample's bytes are stored at consecutive addresses with `smp_data[7:0]` first. A narrow sample (`smp_wide`=0) stores `smp_data[15:0]` as 2 bytes. A wide sample (`smp_wide`=1) stores all 4 bytes.
- R3: In the cycle after the write that fills the last byte of a half, `dma_req` is high and `dma_half` names that half, with 0 being the half at byte addresses 0..63.
- R4: While a request is pending, samples keep being accepted into the other half without loss until all 128 bytes are held.
- R5: `dma_req` stays high until a `dma_ack` pulse. The acknowledge frees the half named by `dma_half` from the next cycle. An acknowledge while `dma_req` is low has no effect.
- R6: Halves are requested in the order they were filled. If both halves are full, an acknowledge moves `dma_half` to the other half and `dma_req` stays high.
- R7: A sample larger than the free space is discarded entirely and no byte of it is written. This includes a wide sample arriving with only 2 bytes free. The cycle after a discarded sample, `bw_err` is high.
- R8: `bw_err` stays high until `err_clr` is asserted. If a discard and `err_clr` occur in the same cycle, the flag remains set.
- R9: A wide sample arriving with 2 bytes left in a half puts its low 2 bytes at the end of that half and its high 2 bytes at the start of the other half.
- R10: `rd_data` returns the byte at offset `rd_addr` within half `dma_half`, one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_wide | input | 1 | 1 = 4-byte sample, 0 = 2-byte sample |
| smp_data | input | 32 | Sample bytes, least significant first in memory |
| dma_req | output | 1 | A full half awaits draining |
| dma_half | output | 1 | Index of the half to drain |
| dma_ack | input | 1 | Pulse: the requested half has been read |
| rd_addr | input | 6 | Byte offset within the requested half |
| rd_data | output | 8 | Byte read, one cycle after `rd_addr` |
| err_clr | input | 1 | Clears the bandwidth-error flag |
| bw_err | output | 1 | Sticky: a sample was discarded |

## Verification
Any error in the write pointer shows up on the next drain as a byte out of place. This is visible as soon as the affected half is read back, and often earlier, because `dma_req` rises one sample too soon or too late. A wrong full-half count shows up on the ports in one of three ways. A sample may be discarded while room remains, which raises `bw_err` one cycle later. A sample may be accepted into a half still owned by the drain, which corrupts bytes the bench reads back. Or `dma_req` may fail to fall after the final acknowledge. The drain order is exposed by `dma_half` on the cycle after each acknowledge.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  // Sample sizes in bytes
  localparam int unsigned NARROW_BYTES = 2;
  localparam int unsigned WIDE_BYTES   = 4;
endpackage

// File: rtl/capbuf_store.sv
module capbuf_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_base,
  input  logic [LW-1:0]      wr_len,
  input  logic [LANES*8-1:0] wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_q
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] lane_addr [LANES];
  logic [LANES-1:0] lane_en;

  // One write port per byte lane, address wraps around the store
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = wr_base + AW'(k);
    assign lane_en[k]   = wr_en && (LW'(k) < wr_len);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_en[k]) mem[lane_addr[k]] <= wr_data[k*8 +: 8];
    end
  end

  logic [7:0] rd_q_nxt;
  assign rd_q_nxt = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_q_nxt;
  end
endmodule

// File: rtl/capbuf_fill.sv
module capbuf_fill
  import capbuf_pkg::*;
#(
  parameter int unsigned HALF  = 64,
  parameter int unsigned LANES = 4,
  localparam int unsigned HW   = $clog2(HALF),
  localparam int unsigned AW   = HW + 1,
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned LW   = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic          smp_wide,
  input  logic          err_clr,
  input  logic [1:0]    full_cnt,
  output logic          wr_en,
  output logic [AW-1:0] wr_base,
  output logic [LW-1:0] wr_len,
  output logic          half_done,
  output logic          bw_err
);
  logic [AW-1:0] wr_ptr, wr_ptr_nxt;
  logic          err_nxt;
  logic [CW-1:0] size, occ, room, fill_end;
  logic          accept, drop;

  always_comb begin
    size      = smp_wide ? CW'(WIDE_BYTES) : CW'(NARROW_BYTES);
    occ       = {full_cnt, {HW{1'b0}}} + {{(CW-HW){1'b0}}, wr_ptr[HW-1:0]};
    room      = CW'(2 * HALF) - occ;
    accept    = smp_valid && (size <= room);
    drop      = smp_valid && !accept;
    fill_end  = {{(CW-HW){1'b0}}, wr_ptr[HW-1:0]} + size;
    half_done = accept && (fill_end >= CW'(HALF));
    wr_ptr_nxt = accept ? wr_ptr + AW'(size) : wr_ptr;
    if (drop)         err_nxt = 1'b1;
    else if (err_clr) err_nxt = 1'b0;
    else              err_nxt = bw_err;
  end

  assign wr_en   = accept;
  assign wr_base = wr_ptr;
  assign wr_len  = LW'(size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      bw_err <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      bw_err <= err_nxt;
    end
  end

  // R7: a full store never takes a sample
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && full_cnt == 2'd2) |-> !wr_en);
  // R7: a discarded sample raises the flag
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !wr_en) |=> bw_err);
  // R8: the flag holds without a clear
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_err && !err_clr) |=> bw_err);
endmodule

// File: rtl/capbuf_drain.sv
module capbuf_drain (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_done,
  input  logic       dma_ack,
  output logic [1:0] full_cnt,
  output logic       dma_req,
  output logic       dma_half
);
  logic [1:0] cnt_nxt;
  logic       half_nxt, ack_ok;

  always_comb begin
    ack_ok   = dma_ack && dma_req;
    cnt_nxt  = full_cnt + {1'b0, half_done} - {1'b0, ack_ok};
    half_nxt = ack_ok ? ~dma_half : dma_half;
  end

  assign dma_req = (full_cnt != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_cnt <= 2'd0;
      dma_half <= 1'b0;
    end else begin
      full_cnt <= cnt_nxt;
      dma_half <= half_nxt;
    end
  end

  // R4: never more than two halves pending
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_cnt <= 2'd2);
  // R5: request holds until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);
  // R6: with both halves full, an acknowledge advances to the other half
  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && full_cnt == 2'd2) |=> (dma_req && dma_half != $past(dma_half)));
endmodule

// File: rtl/pingpong_capbuf.sv
module pingpong_capbuf #(
  parameter int unsigned HALF  = 64,
  parameter int unsigned LANES = 4,
  localparam int unsigned HW   = $clog2(HALF),
  localparam int unsigned AW   = HW + 1,
  localparam int unsigned LW   = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic               smp_wide,
  input  logic [LANES*8-1:0] smp_data,
  output logic               dma_req,
  output logic               dma_half,
  input  logic               dma_ack,
  input  logic [HW-1:0]      rd_addr,
  output logic [7:0]         rd_data,
  input  logic               err_clr,
  output logic               bw_err
);
  logic [1:0]    full_cnt;
  logic          wr_en, half_done;
  logic [AW-1:0] wr_base;
  logic [LW-1:0] wr_len;

  capbuf_fill #(.HALF(HALF), .LANES(LANES)) u_fill (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_wide(smp_wide),
    .err_clr(err_clr), .full_cnt(full_cnt), .wr_en(wr_en), .wr_base(wr_base),
    .wr_len(wr_len), .half_done(half_done), .bw_err(bw_err)
  );

  capbuf_drain u_drain (
    .clk(clk), .rst_n(rst_n), .half_done(half_done), .dma_ack(dma_ack),
    .full_cnt(full_cnt), .dma_req(dma_req), .dma_half(dma_half)
  );

  capbuf_store #(.DEPTH(2 * HALF), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_base(wr_base), .wr_len(wr_len),
    .wr_data(smp_data), .rd_addr({dma_half, rd_addr}), .rd_q(rd_data)
  );

  // R3: a half completing from empty raises the request next cycle
  p_req_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_done && !dma_req) |=> dma_req);
endmodule

// File: tb/pingpong_capbuf_test.sv
module pingpong_capbuf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0, smp_wide = 1'b0, dma_ack = 1'b0, err_clr = 1'b0;
  logic [31:0] smp_data = '0;
  logic [5:0]  rd_addr = '0;
  logic        dma_req, dma_half, bw_err;
  logic [7:0]  rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pingpong_capbuf uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_wide(smp_wide),
    .smp_data(smp_data), .dma_req(dma_req), .dma_half(dma_half), .dma_ack(dma_ack),
    .rd_addr(rd_addr), .rd_data(rd_data), .err_clr(err_clr), .bw_err(bw_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit wide, input logic [31:0] d);
    smp_valid = 1'b1; smp_wide = wide; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic push_narrow(input byte b0, input byte b1);
    push(1'b0, {16'h0, b1, b0});
  endtask

  task automatic push_wide(input byte b0);
    push(1'b1, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0});
  endtask

  task automatic ack();
    dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
  endtask

  task automatic clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    rd_addr = 6'(a);
    @(negedge clk);
    check(rd_data == 8'(exp), tag, rd_data, exp);
  endtask

  task automatic t_reset();
    check(dma_req == 1'b0, "R1 req after reset", dma_req, 0);
    check(bw_err == 1'b0, "R1 err after reset", bw_err, 0);
  endtask

  task automatic t_first_half();
    for (int i = 0; i < 15; i++) push_wide(byte'(4 * i));
    check(dma_req == 1'b0, "R3 no req before half full", dma_req, 0);
    push_wide(8'd60);
    check(dma_req == 1'b1, "R3 req when half full", dma_req, 1);
    check(dma_half == 1'b0, "R3 first half index", dma_half, 0);
    rd(0, 0, "R10 byte 0");
    rd(1, 1, "R2 byte order");
    rd(37, 37, "R2 mid byte");
    rd(63, 63, "R10 last byte");
  endtask

  task automatic t_second_half_and_overflow();
    for (int j = 0; j < 32; j++) push_narrow(byte'(8'h40 + 2 * j), byte'(8'h41 + 2 * j));
    check(bw_err == 1'b0, "R4 no loss while draining", bw_err, 0);
    check(dma_req == 1'b1 && dma_half == 1'b0, "R5 req held on half 0", {dma_req, dma_half}, 2);
    push_narrow(8'hEE, 8'hEE);
    check(bw_err == 1'b1, "R7 err on full store", bw_err, 1);
    repeat (3) @(negedge clk);
    check(bw_err == 1'b1, "R8 err sticky", bw_err, 1);
    clr();
    check(bw_err == 1'b0, "R8 err cleared", bw_err, 0);
    smp_valid = 1'b1; smp_wide = 1'b1; smp_data = 32'hEEEEEEEE; err_clr = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; err_clr = 1'b0;
    check(bw_err == 1'b1, "R8 set beats clear", bw_err, 1);
    clr();
    ack();
    check(dma_req == 1'b1 && dma_half == 1'b1, "R6 advance to half 1", {dma_req, dma_half}, 3);
    rd(0, 8'h40, "R7 dropped bytes not written");
    rd(1, 8'h41, "R4 half 1 byte 1");
    rd(63, 8'h7F, "R4 half 1 last byte");
    ack();
    check(dma_req == 1'b0, "R5 req falls after last ack", dma_req, 0);
    ack();
    check(dma_req == 1'b0 && dma_half == 1'b0, "R5 stray ack ignored", {dma_req, dma_half}, 0);
  endtask

  task automatic t_straddle();
    for (int j = 0; j < 31; j++) push_narrow(byte'(2 * j), byte'(2 * j + 1));
    check(dma_req == 1'b0, "R5 stray ack freed nothing extra", dma_req, 0);
    push(1'b1, 32'hA3A2A1A0);
    check(dma_req == 1'b1 && dma_half == 1'b0, "R9 straddle completes half 0", {dma_req, dma_half}, 2);
    rd(61, 61, "R9 byte before split");
    rd(62, 8'hA0, "R9 low byte at end");
    rd(63, 8'hA1, "R9 second byte at end");
    ack();
    for (int k = 0; k < 15; k++) push_wide(byte'(8'h82 + 4 * k));
    push_narrow(8'hBE, 8'hBF);
    check(dma_req == 1'b1 && dma_half == 1'b1, "R3 req for half 1", {dma_req, dma_half}, 3);
    rd(0, 8'hA2, "R9 high bytes start half 1");
    rd(1, 8'hA3, "R9 top byte");
    rd(2, 8'h82, "R2 wide after split");
    rd(63, 8'hBF, "R2 narrow high byte");
  endtask

  task automatic t_partial_fit();
    for (int j = 0; j < 31; j++) push_narrow(byte'(2 * j), byte'(2 * j + 1));
    check(bw_err == 1'b0, "R7 no err with room", bw_err, 0);
    push(1'b1, 32'hEEEEEEEE);
    check(bw_err == 1'b1, "R7 wide dropped with 2 free", bw_err, 1);
    check(dma_req == 1'b1 && dma_half == 1'b1, "R7 drop leaves request", {dma_req, dma_half}, 3);
    push_narrow(8'h5C, 8'h5D);
    ack();
    check(dma_req == 1'b1 && dma_half == 1'b0, "R6 fill order kept", {dma_req, dma_half}, 2);
    rd(62, 8'h5C, "R7 nothing of dropped wide stored");
    rd(63, 8'h5D, "R7 following narrow stored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_half();
    t_second_half_and_overflow();
    t_straddle();
    t_partial_fit();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule